// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is a single-master I2C engine that performs exactly one bus byte for every command word software writes. A command word can ask for a start condition (or a repeated start when the bus is still held from an earlier byte), carries the byte to shift out, selects whether the master drives the acknowledge slot low or leaves it released, and can ask for a stop condition. The block drives open-drain SCL and SDA through active-high pull-low enables, samples the acknowledge, and watches for lost arbitration. Completion is signalled only by a one-cycle interrupt pulse. The result sits in a status word: the sampled acknowledge, the arbitration-lost flag and the byte seen on SDA.

The block's direction is set by the last address byte. After a start whose byte has bit 0 set, later commands without start release SDA during the data bits and collect the slave's byte. Software acknowledges each read byte with NACK clear and marks the final one with NACK set. A command with stop set and start clear only closes the transfer. Software sets the SCL timing through a clock word. Two control bits gate the whole engine. There is no streaming interface: commands enter through a plain register port. This port has no back-pressure: a command written while a byte is in progress is dropped.

Register offsets (reg_addr): 0 command, 1 status, 2 clock, 3 control. The register read path is combinational.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, the control register reads 0, and the clock register reads 0x007D_00FA (high count 125 in bits 31:16, period 250 in bits 15:0).
- R2: A command word has its byte in bits 7:0, NACK in bit 8, stop in bit 9 and start in bit 10. A command with start set on an idle bus produces a start condition (SDA falls while SCL is high), then the 8 byte bits MSB first, then a ninth acknowledge clock. SDA changes only while SCL is low.
- R3: Let H be bits 31:16 of the clock word and L the period (bits 15:0) minus H, both at least 1. A start from idle takes H cycles. A repeated start takes L+2H. Each of the 9 bit slots takes L+H, with SCL low then high. A stop takes L+2H. irq goes high on the cycle after the last phase ends.
- R4: irq is a pulse exactly one cycle wide. After it, status bit 11 holds the SDA level sampled in the acknowledge slot (1 means not acknowledged).
- R5: After a start whose byte has bit 0 = 1, commands without start release SDA during the 8 data bits. The sampled byte appears MSB first in status bits 7:0. The master pulls SDA low in the acknowledge slot when NACK is 0 and releases it when NACK is 1.
- R6: A byte without stop leaves SCL held low. A start command then produces a repeated start: SDA released, SCL released, then SDA falls while SCL is high.
- R7: A command with stop set and start clear, sent while the bus is held, produces only a stop condition: SDA rises while SCL is high, and afterwards both lines are released.
- R8: If SDA reads low at the end of a SCL-high time while the master is releasing it for a transmitted 1, the master releases both lines on the next cycle. It also sets status bit 9, pulses irq, and generates no stop.
- R9: The engine runs only while control bits 1:0 are both 1. Otherwise both lines are released, commands are ignored and any held bus is dropped.
- R10: A command written while a byte is in progress is ignored.
- R11: SDA never changes while SCL is high inside a bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sda_in | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase state or bit index shows up first in the timing. The command-to-interrupt cycle count moves off its arithmetic value on that same byte, and the slave model captures a shifted or truncated byte. A wrong direction or acknowledge flag shows up in the status word read right after the pulse. With a wrong held-bus flag, SCL is left released or held at the next check, or a repeated start turns into a plain start with a shorter count. The byte sweeps cover every value in both directions, so a stuck or swapped shift bit appears within a single byte.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RS_LOW,
    PH_RS_HIGH,
    PH_START,
    PH_BIT_LOW,
    PH_BIT_HIGH,
    PH_STOP_LOW,
    PH_STOP_HIGH,
    PH_STOP_FREE
  } phase_e;

  localparam int CMD_START = 10;
  localparam int CMD_STOP  = 9;
  localparam int CMD_NACK  = 8;
  localparam int STS_NACKED = 11;
  localparam int STS_LOST   = 9;

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_STS = 2'd1;
  localparam logic [1:0] ADDR_CLK = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;
endpackage

// File: rtl/i2c_bm_timer.sv
module i2c_bm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (load)       cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !last) |=> (cnt < $past(cnt))); // R3
endmodule

// File: rtl/i2c_bm_shift.sv
module i2c_bm_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              step,
  input  logic              sin,
  output logic              tx_msb,
  output logic [BYTE_W-1:0] rx
);
  logic [BYTE_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else if (load) begin
      tx <= din;
    end else if (step) begin
      tx <= {tx[BYTE_W-2:0], 1'b0};
      rx <= {rx[BYTE_W-2:0], sin};
    end
  end

  assign tx_msb = tx[BYTE_W-1];
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              go,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_nack,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [CNT_W-1:0]  len_low,
  input  logic [CNT_W-1:0]  len_high,
  input  logic              sda_in,
  output logic              scl_drv,
  output logic              sda_drv,
  output logic              irq,
  output logic              nacked,
  output logic              lost_flag,
  output logic              busy,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  phase_e           state, nxt;
  logic [CNT_W-1:0] nxt_len;
  logic             ld, finish, lose, last, held;
  logic             start_q, stop_q, nack_q, rd_mode;
  logic [IDX_W-1:0] bitn;
  logic             tx_msb, step, accept;
  logic             data_slot, rd_eff, bit_low, arb_check;

  assign accept    = (state == PH_IDLE) && go && run;
  assign data_slot = (bitn != ACK_IDX);
  assign rd_eff    = rd_mode & ~start_q;
  assign bit_low   = data_slot ? (~rd_eff & ~tx_msb) : ~nack_q;
  assign arb_check = data_slot & ~rd_eff & tx_msb;
  assign step      = (state == PH_BIT_HIGH) && last && data_slot;

  always_comb begin
    nxt     = state;
    nxt_len = len_low;
    ld      = 1'b0;
    finish  = 1'b0;
    lose    = 1'b0;
    case (state)
      PH_IDLE: if (go) begin
        ld = 1'b1;
        if (cmd_start) begin
          if (held) nxt = PH_RS_LOW;
          else begin nxt = PH_START; nxt_len = len_high; end
        end else if (cmd_stop) nxt = PH_STOP_LOW;
        else                   nxt = PH_BIT_LOW;
      end
      PH_RS_LOW:    if (last) begin nxt = PH_RS_HIGH;   nxt_len = len_high; ld = 1'b1; end
      PH_RS_HIGH:   if (last) begin nxt = PH_START;     nxt_len = len_high; ld = 1'b1; end
      PH_START:     if (last) begin nxt = PH_BIT_LOW;                       ld = 1'b1; end
      PH_BIT_LOW:   if (last) begin nxt = PH_BIT_HIGH;  nxt_len = len_high; ld = 1'b1; end
      PH_BIT_HIGH: if (last) begin
        if (arb_check && !sda_in) begin
          nxt = PH_IDLE; lose = 1'b1; finish = 1'b1;
        end else if (!data_slot) begin
          if (stop_q) begin nxt = PH_STOP_LOW; ld = 1'b1; end
          else begin nxt = PH_IDLE; finish = 1'b1; end
        end else begin
          nxt = PH_BIT_LOW; ld = 1'b1;
        end
      end
      PH_STOP_LOW:  if (last) begin nxt = PH_STOP_HIGH; nxt_len = len_high; ld = 1'b1; end
      PH_STOP_HIGH: if (last) begin nxt = PH_STOP_FREE; nxt_len = len_high; ld = 1'b1; end
      PH_STOP_FREE: if (last) begin nxt = PH_IDLE; finish = 1'b1; end
      default:      nxt = PH_IDLE;
    endcase
  end

  i2c_bm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run),
    .load (ld && run),
    .len  (nxt_len),
    .last (last)
  );

  i2c_bm_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (cmd_byte),
    .step  (step && run),
    .sin   (sda_in),
    .tx_msb(tx_msb),
    .rx    (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      held      <= 1'b0;
      irq       <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      nack_q    <= 1'b0;
      rd_mode   <= 1'b0;
      bitn      <= '0;
      nacked    <= 1'b0;
      lost_flag <= 1'b0;
    end else if (!run) begin
      state <= PH_IDLE;
      held  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= nxt;
      irq   <= finish;
      if (accept) begin
        start_q   <= cmd_start;
        stop_q    <= cmd_stop;
        nack_q    <= cmd_nack;
        lost_flag <= 1'b0;
        bitn      <= '0;
        if (cmd_start) rd_mode <= cmd_byte[0];
      end
      if (state == PH_BIT_HIGH && last) begin
        if (!data_slot) nacked <= sda_in;
        else            bitn   <= bitn + 1'b1;
      end
      if (lose) begin
        lost_flag <= 1'b1;
        held      <= 1'b0;
      end else if (finish) begin
        held <= (state == PH_BIT_HIGH);
      end
    end
  end

  assign scl_drv = (state inside {PH_RS_LOW, PH_BIT_LOW, PH_STOP_LOW}) ||
                   (state == PH_IDLE && held);
  assign sda_drv = (state inside {PH_START, PH_STOP_LOW, PH_STOP_HIGH}) ||
                   ((state inside {PH_BIT_LOW, PH_BIT_HIGH}) && bit_low);
  assign busy    = (state != PH_IDLE);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_BIT_HIGH && !last && run) |=> $stable(sda_drv)); // R11
  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (lose && run) |=> (!scl_drv && !sda_drv)); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && run) |=> ($stable(start_q) && $stable(stop_q) && $stable(nack_q))); // R10
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_PERIOD  = 250,
  parameter int DEF_HIGH    = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam int BYTE_W = 8;
  localparam logic [31:0] CLK_RST = {16'(DEF_HIGH), 16'(DEF_PERIOD)};

  logic [31:0]       cmd_q, clk_q;
  logic [1:0]        ctl_q;
  logic              run, go;
  logic [CNT_W-1:0]  len_high, len_low;
  logic              scl_drv, sda_drv, nacked, lost_flag, eng_busy;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      clk_q <= CLK_RST;
      ctl_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_CMD: cmd_q <= reg_wdata;
        ADDR_CLK: clk_q <= reg_wdata;
        ADDR_CTL: ctl_q <= reg_wdata[1:0];
        default:  ;
      endcase
    end
  end

  assign run      = &ctl_q;
  assign go       = reg_wr && (reg_addr == ADDR_CMD);
  assign len_high = clk_q[16 +: CNT_W];
  assign len_low  = clk_q[CNT_W-1:0] - len_high;

  i2c_bm_engine #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .go       (go),
    .cmd_start(reg_wdata[CMD_START]),
    .cmd_stop (reg_wdata[CMD_STOP]),
    .cmd_nack (reg_wdata[CMD_NACK]),
    .cmd_byte (reg_wdata[BYTE_W-1:0]),
    .len_low  (len_low),
    .len_high (len_high),
    .sda_in   (sda_in),
    .scl_drv  (scl_drv),
    .sda_drv  (sda_drv),
    .irq      (irq),
    .nacked   (nacked),
    .lost_flag(lost_flag),
    .busy     (eng_busy),
    .rx_byte  (rx_byte)
  );

  assign scl_oe = run & scl_drv;
  assign sda_oe = run & sda_drv;

  always_comb begin
    case (reg_addr)
      ADDR_CMD: reg_rdata = cmd_q;
      ADDR_STS: reg_rdata = {20'b0, nacked, 1'b0, lost_flag, 1'b0, rx_byte};
      ADDR_CLK: reg_rdata = clk_q;
      default:  reg_rdata = {30'b0, ctl_q};
    endcase
  end

  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !eng_busy); // R9
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HI = 3;
  localparam int PER = 8;
  localparam int LO = PER - HI;
  localparam int T_BIT = LO + HI;
  localparam int T_BYTE = 9 * T_BIT;
  localparam int T_RS = LO + 2 * HI;
  localparam int T_STOP = LO + 2 * HI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic s_low = 1'b0, other_low = 1'b0;
  logic scl_line, sda_line;

  int checks = 0, fails = 0;
  int rcount = 0, starts = 0, stops = 0;
  logic [7:0] cap = 8'd0, s_byte = 8'd0;
  logic s_ack_en = 1'b0, s_data_en = 1'b0, arb_arm = 1'b0, arb_pending = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_low | other_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  // bus monitor and slave model, sampled away from the active edge
  always @(negedge clk) begin
    if (scl_p && scl_line && sda_p && !sda_line) begin
      starts++; rcount = 0; cap = 8'd0;
      if (arb_arm) arb_pending = 1'b1;
    end
    if (scl_p && scl_line && !sda_p && sda_line) stops++;
    if (!scl_p && scl_line) begin
      if (rcount < 8) cap = {cap[6:0], sda_line};
      rcount++;
    end
    if (scl_p && !scl_line) begin
      if (arb_pending) begin other_low = 1'b1; arb_pending = 1'b0; arb_arm = 1'b0; end
      if (rcount >= 1 && rcount < 8) s_low = s_data_en && !s_byte[7-rcount];
      else if (rcount == 8) s_low = s_ack_en;
      else if (rcount >= 9) s_low = 1'b0;
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic do_cmd(input logic [31:0] cmd, input bit inject, output int n);
    @(posedge clk); #1;
    rcount = 0; cap = 8'd0;
    s_low = s_data_en ? !s_byte[7] : 1'b0;
    @(negedge clk); reg_addr = 2'd0; reg_wdata = cmd; reg_wr = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk); reg_wr = 1'b0; n++;
      if (inject && n == 10) begin reg_wdata = 32'h200; reg_wr = 1'b1; end
      if (irq) break;
      if (n > 2000) begin
        fails++; checks++;
        $display("FAIL R3 no irq actual=%0d expected=irq", n);
        break;
      end
    end
  endtask

  task automatic pulse_gone;
    @(negedge clk); reg_wr = 1'b0;
    chk("R4 irq one cycle", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, st0, sp0;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", {31'b0, scl_oe}, 0);
    chk("R1 sda_oe", {31'b0, sda_oe}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(2'd2, v); chk("R1 clock word", v, 32'h007D_00FA);
    rd(2'd3, v); chk("R1 control", v, 0);

    // R9 command ignored while control is 0
    write_reg(2'd0, 32'h5A0);
    seen = 0;
    repeat (30) begin @(negedge clk); if (irq || scl_oe || sda_oe) seen = 1; end
    chk("R9 ignored while off", {31'b0, seen}, 0);

    write_reg(2'd2, {16'(HI), 16'(PER)});
    write_reg(2'd3, 32'h3);

    // R2/R3 start + address write from idle
    s_ack_en = 1; s_data_en = 0;
    do_cmd(32'h5A0, 0, n);
    chk("R3 start byte cycles", n, HI + T_BYTE + 1);
    chk("R2 captured address", {24'b0, cap}, 32'hA0);
    chk("R2 start seen", starts, 1);
    rd(2'd1, v);
    chk("R4 ack sampled", {31'b0, v[11]}, 0);
    chk("R8 no loss", {31'b0, v[9]}, 0);
    pulse_gone();
    chk("R6 bus held", {31'b0, scl_oe}, 1);

    // R2/R3/R4 exhaustive write data sweep
    for (int b = 0; b < 256; b++) begin
      s_ack_en = ~b[0];
      do_cmd(32'h100 | b, 0, n);
      chk("R3 data byte cycles", n, T_BYTE + 1);
      chk("R2 data byte msb first", {24'b0, cap}, b);
      rd(2'd1, v);
      chk("R4 ack bit", {31'b0, v[11]}, {31'b0, b[0]});
    end

    // R10 command while busy ignored
    s_ack_en = 1; sp0 = stops;
    do_cmd(32'h1FF, 1, n);
    chk("R10 busy cycles", n, T_BYTE + 1);
    chk("R10 byte intact", {24'b0, cap}, 32'hFF);
    pulse_gone();
    chk("R10 still held", {31'b0, scl_oe}, 1);
    chk("R10 no stop", stops, sp0);

    // R6 repeated start with read address
    st0 = starts;
    do_cmd(32'h5A1, 0, n);
    chk("R6 repeated start cycles", n, T_RS + T_BYTE + 1);
    chk("R6 start count", starts, st0 + 1);
    chk("R6 address captured", {24'b0, cap}, 32'hA1);
    pulse_gone();

    // R5 exhaustive read sweep
    s_ack_en = 0; s_data_en = 1;
    for (int k = 0; k < 256; k++) begin
      s_byte = 8'(k);
      do_cmd((k == 255) ? 32'h100 : 32'h000, 0, n);
      chk("R5 read cycles", n, T_BYTE + 1);
      rd(2'd1, v);
      chk("R5 read byte", {24'b0, v[7:0]}, k);
      chk("R5 master ack", {31'b0, v[11]}, (k == 255) ? 1 : 0);
    end
    s_data_en = 0;

    // R7 stop only
    sp0 = stops;
    do_cmd(32'h300, 0, n);
    chk("R7 stop cycles", n, T_STOP + 1);
    chk("R7 stop seen", stops, sp0 + 1);
    pulse_gone();
    chk("R7 scl released", {31'b0, scl_oe}, 0);
    chk("R7 sda released", {31'b0, sda_oe}, 0);

    // R8 arbitration loss on first address bit
    s_ack_en = 1; arb_arm = 1; sp0 = stops;
    do_cmd(32'h5A0, 0, n);
    chk("R8 loss cycles", n, HI + T_BIT + 1);
    chk("R8 lines released", {30'b0, scl_oe, sda_oe}, 0);
    rd(2'd1, v);
    chk("R8 lost bit", {31'b0, v[9]}, 1);
    repeat (40) @(negedge clk);
    chk("R8 no stop generated", stops, sp0);
    other_low = 0;
    repeat (5) @(negedge clk);

    // R9 control bits drop a held bus
    do_cmd(32'h5A0, 0, n);
    chk("R3 start after loss", n, HI + T_BYTE + 1);
    pulse_gone();
    chk("R9 held before", {31'b0, scl_oe}, 1);
    write_reg(2'd3, 32'h1);
    chk("R9 released when off", {30'b0, scl_oe, sda_oe}, 0);
    write_reg(2'd3, 32'h3);
    chk("R9 held dropped", {31'b0, scl_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule